// File: doc/BRIEF.md
# Instruction-Triggered Standby Controller

This block puts a small processor core into one of two low-power standby states when the decoder hands it a standby request. A light standby freezes instruction fetch by holding the core stall high while the oscillator keeps running. A deep standby also turns the oscillator off. The request carries a 4-bit operand. Bit 0 of that operand chooses how the standby may be left. With bit 0 clear, only the system reset can end it. With bit 0 set, a high level on an external wake pin can end it as well.

A request with bit 0 set that arrives while the synchronized wake level is already high does nothing, and the core carries on. Leaving standby through the pin lets the core continue with the next instruction. Leaving through reset raises a one-cycle restart-at-zero pulse so the core fetches from address zero.

When deep standby ends through the pin, the oscillator enable comes back on first. The stall is then held for a settling interval before the core is released. The whole block runs on an always-on clock, so the wake detection and the settling count keep working while the core oscillator is off.

Top module: `standby_ctrl`

## Requirements
- R1: While `rst` is sampled high, the next cycle shows `core_stall`=0, `osc_en`=1, `operand_err`=0 and `restart_zero`=1. `restart_zero` is 0 in every cycle that does not follow a cycle with `rst` high.
- R2: A light request (`req_stop`=0) with operand bit 0 = 0 raises `core_stall` from the cycle after it is sampled and keeps `osc_en`=1. The wake pin has no effect on it; only `rst` ends it.
- R3: A deep request (`req_stop`=1) with operand bit 0 = 0 raises `core_stall` and drops `osc_en` from the cycle after it is sampled. The wake pin has no effect on it; only `rst` ends it.
- R4: A request with operand bit 0 = 1, sampled while the synchronized wake level is low, enters the requested standby exactly as in R2 or R3.
- R5: A request with operand bit 0 = 1, sampled while the synchronized wake level is high, acts as a no-operation: `core_stall` and `osc_en` do not change.
- R6: In light standby with pin release armed, `core_stall` falls on the third rising clock edge after `wake_pin` goes high (two synchronizer stages plus one state update), and `restart_zero` stays 0.
- R7: In deep standby with pin release armed, `osc_en` rises on that same third edge. `core_stall` then stays high for exactly `SETTLE_CYC` more cycles before it falls, and `restart_zero` stays 0.
- R8: Reset takes priority over a wake in the same cycle and over a settling interval in progress. It also clears the settling count, so a later deep standby waits the full `SETTLE_CYC` again.
- R9: A request accepted while the core is running, with any of operand bits 3..1 set, raises `operand_err` for exactly the next cycle. The request is still handled using bit 0 alone.
- R10: Whenever `osc_en` is 0, `core_stall` is 1. When `osc_en` rises outside reset, `core_stall` is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high system reset |
| req_valid | input | 1 | Decoded standby request, one cycle |
| req_stop | input | 1 | 1 = deep standby (oscillator off), 0 = light standby |
| req_operand | input | OPW | Request operand; bit 0 arms pin release, upper bits must be 0 |
| wake_pin | input | 1 | Asynchronous wake level, active high |
| core_stall | output | 1 | Holds the core's program counter |
| osc_en | output | 1 | Core oscillator enable |
| restart_zero | output | 1 | One-cycle pulse after reset: fetch from address zero |
| operand_err | output | 1 | One-cycle flag for an operand with nonzero upper bits |

## Verification
On every cycle, the assertions check the effect of reset on all outputs, that the oscillator is never off while the core runs, and that the stall still covers a rising oscillator enable. They also check that an armed request seen with the wake level high leaves the core running, and that a bad operand raises the flag. Only the bench scenarios can show the exact wake latency through the synchronizer, the length of the settling interval and its restart after a reset. They also show that the wake pin cannot end a reset-only standby, and that a pin release never produces a restart pulse.

// File: rtl/standby_pkg.sv
package standby_pkg;

  typedef enum logic [1:0] {
    SB_RUN    = 2'd0,
    SB_LIGHT  = 2'd1,
    SB_DEEP   = 2'd2,
    SB_SETTLE = 2'd3
  } sb_state_e;

  function automatic logic sb_is_stalled(input sb_state_e s);
    return s != SB_RUN;
  endfunction

  function automatic logic sb_osc_on(input sb_state_e s);
    return s != SB_DEEP;
  endfunction

endpackage

// File: rtl/sb_wake_sync.sv
module sb_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain_q;

  generate
    genvar g;
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain_q[0] <= 1'b0;
          else     chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain_q[g] <= 1'b0;
          else     chain_q[g] <= chain_q[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];
endmodule

// File: rtl/sb_settle_timer.sv
module sb_settle_timer #(
  parameter int CYC = 256
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic done
);
  localparam int CW = (CYC < 2) ? 1 : $clog2(CYC);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt_q <= '0;
    else if (cnt_q != LAST) cnt_q <= cnt_q + 1'b1;
  end

  assign done = run && (cnt_q == LAST);
endmodule

// File: rtl/sb_fsm.sv
module sb_fsm
  import standby_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic req_stop,
  input  logic req_arm,
  input  logic wake_s,
  input  logic settle_done,
  output logic settle_run,
  output logic accept,
  output logic core_stall,
  output logic osc_en
);
  sb_state_e state_q, state_d;
  logic      arm_q, arm_d;

  assign accept = req_valid && (state_q == SB_RUN);

  always_comb begin
    state_d = state_q;
    arm_d   = arm_q;
    unique case (state_q)
      SB_RUN: begin
        if (accept && !(req_arm && wake_s)) begin
          state_d = req_stop ? SB_DEEP : SB_LIGHT;
          arm_d   = req_arm;
        end
      end
      SB_LIGHT: if (arm_q && wake_s) state_d = SB_RUN;
      SB_DEEP:  if (arm_q && wake_s) state_d = SB_SETTLE;
      SB_SETTLE: if (settle_done) state_d = SB_RUN;
      default: state_d = SB_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SB_RUN;
      arm_q      <= 1'b0;
      core_stall <= 1'b0;
      osc_en     <= 1'b1;
    end else begin
      state_q    <= state_d;
      arm_q      <= arm_d;
      core_stall <= sb_is_stalled(state_d);
      osc_en     <= sb_osc_on(state_d);
    end
  end

  assign settle_run = (state_q == SB_SETTLE);
endmodule

// File: rtl/standby_ctrl.sv
module standby_ctrl #(
  parameter int OPW         = 4,
  parameter int SYNC_STAGES = 2,
  parameter int SETTLE_CYC  = 256
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_stop,
  input  logic [OPW-1:0] req_operand,
  input  logic           wake_pin,
  output logic           core_stall,
  output logic           osc_en,
  output logic           restart_zero,
  output logic           operand_err
);
  logic wake_s;
  logic settle_run;
  logic settle_done;
  logic accept;

  sb_wake_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (wake_pin),
    .sync_out (wake_s)
  );

  sb_settle_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .run  (settle_run),
    .done (settle_done)
  );

  sb_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_stop    (req_stop),
    .req_arm     (req_operand[0]),
    .wake_s      (wake_s),
    .settle_done (settle_done),
    .settle_run  (settle_run),
    .accept      (accept),
    .core_stall  (core_stall),
    .osc_en      (osc_en)
  );

  always_ff @(posedge clk) begin
    restart_zero <= rst;
    if (rst) operand_err <= 1'b0;
    else     operand_err <= accept && (|req_operand[OPW-1:1]);
  end
endmodule

// File: rtl/standby_ctrl_checker.sv
module standby_ctrl_checker #(
  parameter int OPW = 4
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic [OPW-1:0] req_operand,
  input logic           wake_s,
  input logic           core_stall,
  input logic           osc_en,
  input logic           restart_zero,
  input logic           operand_err
);
  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (restart_zero && !core_stall && osc_en && !operand_err)); // R1

  AST_OSC_OFF_STALLED: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> core_stall); // R10

  AST_OSC_RISE_STALLED: assert property (@(posedge clk) disable iff (rst)
    ($rose(osc_en) && !$past(rst)) |-> core_stall); // R7

  AST_NOP_WHEN_WAKE: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !core_stall && req_operand[0] && wake_s) |=> !core_stall); // R5

  AST_BAD_OPERAND_FLAG: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !core_stall && (|req_operand[OPW-1:1])) |=> operand_err); // R9
endmodule

bind standby_ctrl standby_ctrl_checker #(.OPW(OPW)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_operand  (req_operand),
  .wake_s       (wake_s),
  .core_stall   (core_stall),
  .osc_en       (osc_en),
  .restart_zero (restart_zero),
  .operand_err  (operand_err)
);

// File: tb/standby_ctrl_tb_top.sv
`timescale 1ns/1ps
module standby_ctrl_tb_top;
  localparam int S = 12;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic       req_stop = 1'b0;
  logic [3:0] req_operand = '0;
  logic       wake_pin = 1'b0;
  logic       core_stall, osc_en, restart_zero, operand_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  standby_ctrl #(.OPW(4), .SYNC_STAGES(2), .SETTLE_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_stop(req_stop),
    .req_operand(req_operand), .wake_pin(wake_pin), .core_stall(core_stall),
    .osc_en(osc_en), .restart_zero(restart_zero), .operand_err(operand_err));

  function automatic bit exp_enter(input logic [3:0] op, input bit wake_hi);
    return !(op[0] && wake_hi);
  endfunction

  function automatic bit exp_err(input logic [3:0] op);
    return |op[3:1];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input string req);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(restart_zero == 1'b1, req, restart_zero, 1);
    chk(core_stall == 1'b0, req, core_stall, 0);
    chk(osc_en == 1'b1, req, osc_en, 1);
    @(negedge clk);
    chk(restart_zero == 1'b0, {req, " pulse end"}, restart_zero, 0);
  endtask

  task automatic set_wake(input bit v);
    @(negedge clk); wake_pin = v;
    cyc(3);
  endtask

  task automatic issue(input bit stop, input logic [3:0] op, input bit wake_hi);
    bit en;
    en = exp_enter(op, wake_hi);
    @(negedge clk); req_valid = 1'b1; req_stop = stop; req_operand = op;
    @(negedge clk); req_valid = 1'b0; req_operand = '0;
    chk(core_stall == en, en ? "R4 entry stall" : "R5 nop stall", core_stall, en);
    chk(osc_en == !(stop && en), stop ? "R3 osc" : "R2 osc", osc_en, !(stop && en));
    chk(operand_err == exp_err(op), "R9 err flag", operand_err, exp_err(op));
    @(negedge clk);
    chk(operand_err == 1'b0, "R9 err pulse", operand_err, 0);
  endtask

  task automatic wake_release(input bit stop);
    @(negedge clk); wake_pin = 1'b1;
    cyc(2);
    chk(core_stall == 1'b1, "R6 before sync", core_stall, 1);
    @(negedge clk);
    if (!stop) begin
      chk(core_stall == 1'b0, "R6 halt release", core_stall, 0);
      chk(restart_zero == 1'b0, "R6 no restart", restart_zero, 0);
    end else begin
      chk(osc_en == 1'b1, "R7 osc back", osc_en, 1);
      cyc(S - 1);
      chk(core_stall == 1'b1, "R7 settling", core_stall, 1);
      @(negedge clk);
      chk(core_stall == 1'b0, "R7 settle end", core_stall, 0);
      chk(restart_zero == 1'b0, "R7 no restart", restart_zero, 0);
    end
    @(negedge clk); wake_pin = 1'b0;
    cyc(3);
  endtask

  task automatic wake_ignored(input bit stop);
    @(negedge clk); wake_pin = 1'b1;
    cyc(6);
    chk(core_stall == 1'b1, stop ? "R3 pin ignored" : "R2 pin ignored", core_stall, 1);
    chk(osc_en == !stop, stop ? "R3 osc stays off" : "R2 osc stays on", osc_en, !stop);
    @(negedge clk); wake_pin = 1'b0;
    cyc(3);
  endtask

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'h5EED);
    cyc(3);
    @(negedge clk); rst = 1'b0;
    chk(restart_zero == 1'b1 && !core_stall && osc_en && !operand_err,
        "R1 reset state", {restart_zero, core_stall, osc_en, operand_err}, 4'b1010);
    @(negedge clk);
    chk(restart_zero == 1'b0, "R1 restart low", restart_zero, 0);

    // Reset-only light and deep standby
    issue(1'b0, 4'b0000, 1'b0); wake_ignored(1'b0); do_reset("R2 reset release");
    issue(1'b1, 4'b0000, 1'b0); wake_ignored(1'b1); do_reset("R3 reset release");
    // Pin release
    issue(1'b0, 4'b0001, 1'b0); wake_release(1'b0);
    issue(1'b1, 4'b0001, 1'b0); wake_release(1'b1);
    // NOP with wake already high
    set_wake(1'b1); issue(1'b1, 4'b0001, 1'b1); set_wake(1'b0);
    // Bad operand, handled by bit 0 only
    issue(1'b0, 4'b1010, 1'b0); wake_ignored(1'b0); do_reset("R9 bad op reset");
    // Reset in the middle of settling, then full interval again
    issue(1'b1, 4'b0001, 1'b0);
    @(negedge clk); wake_pin = 1'b1;
    cyc(6);
    do_reset("R8 reset during settle");
    @(negedge clk); wake_pin = 1'b0; cyc(3);
    issue(1'b1, 4'b0001, 1'b0); wake_release(1'b1);
    // Reset coincides with wake reaching the state machine
    issue(1'b0, 4'b0001, 1'b0);
    @(negedge clk); wake_pin = 1'b1;
    cyc(1);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk(restart_zero == 1'b1, "R8 reset wins over wake", restart_zero, 1);
    @(negedge clk); wake_pin = 1'b0; cyc(3);

    // Random scenarios
    for (int it = 0; it < 60; it++) begin
      bit stop, wpre, by_pin;
      logic [3:0] op;
      stop = 1'($urandom % 2);
      op = 4'($urandom % 16);
      wpre = 1'($urandom % 2);
      by_pin = 1'($urandom % 2);
      if (wpre) set_wake(1'b1);
      issue(stop, op, wpre);
      if (!exp_enter(op, wpre)) begin
        set_wake(1'b0);
        chk(core_stall == 1'b0, "R5 nop still running", core_stall, 0);
      end else if (op[0] && by_pin) begin
        wake_release(stop);
      end else if (!op[0]) begin
        if (!wpre) wake_ignored(stop);
        else begin
          cyc(4);
          chk(core_stall == 1'b1, "R2 pin high ignored", core_stall, 1);
          @(negedge clk); wake_pin = 1'b0; cyc(3);
        end
        do_reset("R1 random reset");
      end else begin
        do_reset("R4 random reset");
      end
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule